// File: doc/BRIEF.md
# Two-Channel Phase-Current Scaler

This block turns a pair of raw, offset-binary ADC codes into signed Q15 phase currents. A single `start` pulse arms one measurement: the block freezes its four calibration words, then watches the converter's busy flag. Once the flag is low, it reads channel A and, one cycle later, channel B. Both channels go through the same multiplier.

For each channel, the raw code is turned into signed Q15 by flipping its top bit. That value is multiplied by a signed Q13 gain. A signed Q15 offset, shifted up by 13 bits, is added to the product. The 32-bit sum is negated, so that current flowing into the motor reads as positive, and a 16-bit window is cut out of it to give the Q15 result. Both outputs change together in one cycle, marked by a one-cycle valid pulse, and then keep their values until the next measurement.

Top module: `phase_current_scaler`

## Requirements
- R1: While `rstN` is low, and after it is released, `currA`, `currB` and `resultValid` are zero until the first measurement completes.
- R2: A high `start` in an idle cycle launches exactly one measurement. A `start` seen while a measurement is in progress is ignored and does not cause a second result.
- R3: No sample is taken and no result is produced while `adcBusy` is high. The block waits for as many cycles as the flag stays high.
- R4: `sampleA` is read at the first clock edge where `adcBusy` is low during a measurement. `sampleB` is read at the following edge. Neither input is read after that.
- R5: Each raw code is converted to signed Q15 by inverting bit 15. For example, raw 0xC000 is +0.5 and raw 0x8000 is zero.
- R6: The Q15 sample is multiplied by the signed 16-bit Q13 gain into a 32-bit product that wraps modulo 2^32.
- R7: The signed 16-bit offset is sign-extended, shifted left by 13 and added modulo 2^32. With a raw code of 0x8000, the output equals the two's-complement negation of the offset.
- R8: The sum is negated modulo 2^32, and the output is bits 28..13 of the negated value. Results wrap and never saturate. For example, raw 0xC000 with gain 0x2000 and offset 0 gives 0xC000.
- R9: Channel A uses `gainA`/`offsetA` and drives `currA`. Channel B uses `gainB`/`offsetB` and drives `currB`.
- R10: Calibration words are captured at the clock edge that accepts `start`. Changes to them during the measurement have no effect on that measurement's result.
- R11: `resultValid` is high for exactly one cycle, in the same cycle that both outputs first show the new values. The outputs hold steady at all other times.
- R12: `resultValid` goes high after the fourth rising clock edge counted from, and including, the edge at which `adcBusy` is first seen low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches one measurement when idle |
| adcBusy | input | 1 | High while the converter sequence is still running |
| sampleA | input | 16 | First conversion result, offset binary |
| sampleB | input | 16 | Second conversion result, offset binary |
| gainA | input | 16 | Channel A gain, signed Q13 |
| offsetA | input | 16 | Channel A offset, signed Q15 |
| gainB | input | 16 | Channel B gain, signed Q13 |
| offsetB | input | 16 | Channel B offset, signed Q15 |
| currA | output | 16 | Channel A current, signed Q15 |
| currB | output | 16 | Channel B current, signed Q15 |
| resultValid | output | 1 | One-cycle pulse when both outputs update |

## Verification
The assertions assume that `adcBusy` behaves as a level: once it drops during a measurement, it describes a finished conversion. They also assume the sample words are valid exactly at the edges named in R4 and need not hold afterwards. The stimulus puts junk on the sample inputs while busy is high, presents the real codes only in the cycle busy falls, and replaces each code with junk right after the edge that should have consumed it. Calibration inputs are scrambled immediately after the capture edge, and a stray `start` is pulsed mid-measurement, so any read outside the intended windows shows up at the outputs.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CHA,
    ST_CHB,
    ST_FIN
  } pcs_state_t;

  // control-to-datapath strobes; at most one is high per cycle
  typedef struct packed {
    logic capture;  // freeze calibration words
    logic loadA;    // take channel A code into the operand register
    logic stepA;    // finish channel A, take channel B code
    logic stepB;    // finish channel B
    logic finish;   // publish both results
  } pcs_strobe_t;

endpackage

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        adcBusy,
  output pcs_strobe_t strb,
  output logic        resultValid
);

  pcs_state_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start)    stateNext = ST_WAIT;
      ST_WAIT: if (!adcBusy) stateNext = ST_CHA;
      ST_CHA:                stateNext = ST_CHB;
      ST_CHB:                stateNext = ST_FIN;
      ST_FIN:                stateNext = ST_IDLE;
      default:               stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.capture = (state == ST_IDLE) && start;
    strb.loadA   = (state == ST_WAIT) && !adcBusy;
    strb.stepA   = (state == ST_CHA);
    strb.stepB   = (state == ST_CHB);
    strb.finish  = (state == ST_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      resultValid <= 1'b0;
    end else begin
      state       <= stateNext;
      resultValid <= strb.finish;
    end
  end

  // R3: a busy converter keeps the block waiting and silent
  assert_busy_wait_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && adcBusy) |=> (state == ST_WAIT && !resultValid));

  // R11: the valid strobe never lasts two cycles
  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R2: strobes are mutually exclusive
  assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  // R2: a start during a measurement cannot re-arm the capture
  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && start) |-> !strb.capture);

endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FRAC_SHIFT = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcs_strobe_t       strb,
  input  logic [DATA_W-1:0] sampleA,
  input  logic [DATA_W-1:0] sampleB,
  input  logic [DATA_W-1:0] gainA,
  input  logic [DATA_W-1:0] offsetA,
  input  logic [DATA_W-1:0] gainB,
  input  logic [DATA_W-1:0] offsetB,
  output logic [DATA_W-1:0] currA,
  output logic [DATA_W-1:0] currB
);

  localparam int ACC_W = 2 * DATA_W;
  localparam int TOP_B = DATA_W + FRAC_SHIFT - 1;
  localparam logic [DATA_W-1:0] SIGN_FLIP = {1'b1, {(DATA_W-1){1'b0}}};

  logic [NUM_CH-1:0][DATA_W-1:0] gainIn, offIn, gainR, offR;
  assign gainIn = {gainB, gainA};
  assign offIn  = {offsetB, offsetA};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cal
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gainR[ch] <= '0;
        offR[ch]  <= '0;
      end else if (strb.capture) begin
        gainR[ch] <= gainIn[ch];
        offR[ch]  <= offIn[ch];
      end
    end
  end

  // shared arithmetic: channel B selected only while finishing B
  logic [DATA_W-1:0] opnd, gainSel, offSel, scaled;
  logic signed [ACC_W-1:0] opndX, gainX, offX, prod, sum, negd;
  logic unusedBits;

  assign gainSel = strb.stepB ? gainR[1] : gainR[0];
  assign offSel  = strb.stepB ? offR[1]  : offR[0];

  assign opndX = {{(ACC_W-DATA_W){opnd[DATA_W-1]}}, opnd};
  assign gainX = {{(ACC_W-DATA_W){gainSel[DATA_W-1]}}, gainSel};
  assign offX  = {{(ACC_W-DATA_W){offSel[DATA_W-1]}}, offSel};
  assign prod  = opndX * gainX;
  assign sum   = prod + (offX <<< FRAC_SHIFT);
  assign negd  = -sum;
  assign scaled = negd[TOP_B:FRAC_SHIFT];
  assign unusedBits = ^{negd[ACC_W-1:TOP_B+1], negd[FRAC_SHIFT-1:0]};

  logic [DATA_W-1:0] resA, resB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opnd  <= '0;
      resA  <= '0;
      resB  <= '0;
      currA <= '0;
      currB <= '0;
    end else begin
      if (strb.loadA) opnd <= sampleA ^ SIGN_FLIP;
      if (strb.stepA) begin
        resA <= scaled;
        opnd <= sampleB ^ SIGN_FLIP;
      end
      if (strb.stepB) resB <= scaled;
      if (strb.finish) begin
        currA <= resA;
        currB <= resB;
      end
    end
  end

  // R10: calibration only changes at a capture strobe
  assert_cal_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(gainR) && $stable(offR)));

  // R11: outputs move only on publication
  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> ($stable(currA) && $stable(currB)));

  // R4: channel B always follows channel A directly
  assert_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepB |-> $past(strb.stepA));

  // R4: channel A completes right after its code is loaded
  assert_load_then_a_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadA |=> strb.stepA);

endmodule

// File: rtl/phase_current_scaler.sv
module phase_current_scaler
  import pcs_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FRAC_SHIFT = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              adcBusy,
  input  logic [DATA_W-1:0] sampleA,
  input  logic [DATA_W-1:0] sampleB,
  input  logic [DATA_W-1:0] gainA,
  input  logic [DATA_W-1:0] offsetA,
  input  logic [DATA_W-1:0] gainB,
  input  logic [DATA_W-1:0] offsetB,
  output logic [DATA_W-1:0] currA,
  output logic [DATA_W-1:0] currB,
  output logic              resultValid
);

  pcs_strobe_t strb;

  pcs_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .adcBusy     (adcBusy),
    .strb        (strb),
    .resultValid (resultValid)
  );

  pcs_datapath #(
    .DATA_W     (DATA_W),
    .FRAC_SHIFT (FRAC_SHIFT)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .sampleA (sampleA),
    .sampleB (sampleB),
    .gainA   (gainA),
    .offsetA (offsetA),
    .gainB   (gainB),
    .offsetB (offsetB),
    .currA   (currA),
    .currB   (currB)
  );

  // R1: nothing is valid before the first measurement's publication
  assert_no_early_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(strb.finish));

endmodule

// File: tb/phase_current_scaler_bench.sv
`timescale 1ns/1ps
module phase_current_scaler_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic adcBusy = 1'b1;
  logic [15:0] sampleA = '0, sampleB = '0;
  logic [15:0] gainA = '0, offsetA = '0, gainB = '0, offsetB = '0;
  logic [15:0] currA, currB;
  logic resultValid;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  phase_current_scaler u_phase_current_scaler (
    .clk(clk), .rstN(rstN), .start(start), .adcBusy(adcBusy),
    .sampleA(sampleA), .sampleB(sampleB),
    .gainA(gainA), .offsetA(offsetA), .gainB(gainB), .offsetB(offsetB),
    .currA(currA), .currB(currB), .resultValid(resultValid)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // arithmetic as written in R5..R8
  function automatic logic [15:0] model(input logic [15:0] raw,
                                        input logic [15:0] gain,
                                        input logic [15:0] off);
    logic signed [31:0] q, g, o, acc;
    q = 32'(signed'(raw ^ 16'h8000));
    g = 32'(signed'(gain));
    o = 32'(signed'(off));
    acc = -((q * g) + (o <<< 13));
    return acc[28:13];
  endfunction

  task automatic runMeas(input string tag,
                         input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] ga, input logic [15:0] oa,
                         input logic [15:0] gb, input logic [15:0] ob,
                         input logic [15:0] expA, input logic [15:0] expB,
                         input int busyCycles);
    logic [15:0] prevA, prevB;
    prevA = currA;
    prevB = currB;
    @(negedge clk);
    gainA = ga; offsetA = oa; gainB = gb; offsetB = ob;
    start = 1'b1; adcBusy = 1'b1;
    sampleA = ~a; sampleB = ~b;
    @(negedge clk);
    start = 1'b0;
    // R10: scramble calibration right after capture
    gainA = ~ga; offsetA = oa ^ 16'h5a5a; gainB = gb ^ 16'h1234; offsetB = ~ob;
    for (int i = 0; i < busyCycles; i++) begin
      @(negedge clk);
      start = (i == 0);  // R2: stray start mid-measurement
      chk({tag, " R3 no valid while busy"}, {15'd0, resultValid}, 16'd0);
      chk({tag, " R11 currA held"}, currA, prevA);
      sampleA = 16'($urandom);
      sampleB = 16'($urandom);
    end
    sampleA = a; sampleB = b; adcBusy = 1'b0; start = 1'b0;
    @(negedge clk);
    chk({tag, " R12 valid low 1"}, {15'd0, resultValid}, 16'd0);
    sampleA = ~a;  // R4: A must already have been taken
    start = 1'b1;  // R2: ignored
    @(negedge clk);
    chk({tag, " R12 valid low 2"}, {15'd0, resultValid}, 16'd0);
    sampleB = ~b;  // R4: B must already have been taken
    start = 1'b0;
    @(negedge clk);
    chk({tag, " R12 valid low 3"}, {15'd0, resultValid}, 16'd0);
    chk({tag, " R11 currB held"}, currB, prevB);
    @(negedge clk);
    chk({tag, " R12 valid high"}, {15'd0, resultValid}, 16'd1);
    chk({tag, " R9 currA"}, currA, expA);
    chk({tag, " R9 currB"}, currB, expB);
    @(negedge clk);
    chk({tag, " R11 valid one cycle"}, {15'd0, resultValid}, 16'd0);
    chk({tag, " R11 currA hold"}, currA, expA);
    chk({tag, " R11 currB hold"}, currB, expB);
    repeat (5) begin
      @(negedge clk);
      chk({tag, " R2 no second result"}, {15'd0, resultValid}, 16'd0);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 currA in reset", currA, 16'd0);
    chk("R1 currB in reset", currB, 16'd0);
    chk("R1 valid in reset", {15'd0, resultValid}, 16'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 currA after reset", currA, 16'd0);
    chk("R1 valid after reset", {15'd0, resultValid}, 16'd0);
  endtask

  task automatic testKnownValues();
    // R5/R8: +0.5 at unity gain reads -0.5; R7: zero code gives -offset
    runMeas("R5 R8 half", 16'hC000, 16'h8000, 16'h2000, 16'h0000,
            16'h2000, 16'h1000, 16'hC000, 16'hF000, 2);
    // R7: offset only, negative offset gives positive output
    runMeas("R7 offset", 16'h8000, 16'h8000, 16'h7FFF, 16'hF800,
            16'h0100, 16'h0001, 16'h0800, 16'hFFFF, 1);
  endtask

  task automatic testChannels();
    logic [15:0] a, b, ga, oa, gb, ob;
    a = 16'h9234; b = 16'h3100; ga = 16'h1800; oa = 16'h0123; gb = 16'hE400; ob = 16'hFE00;
    runMeas("R9 split cal", a, b, ga, oa, gb, ob,
            model(a, ga, oa), model(b, gb, ob), 6);
  endtask

  task automatic testExtremes();
    // R6/R8 wrapping at the range limits
    runMeas("R6 R8 max", 16'hFFFF, 16'h0000, 16'h7FFF, 16'h7FFF,
            16'h8000, 16'h8000,
            model(16'hFFFF, 16'h7FFF, 16'h7FFF), model(16'h0000, 16'h8000, 16'h8000), 3);
    runMeas("R6 R8 min", 16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF,
            16'h7FFF, 16'h8000,
            model(16'h0000, 16'h8000, 16'h7FFF), model(16'hFFFF, 16'h7FFF, 16'h8000), 1);
  endtask

  task automatic testRandom();
    for (int n = 0; n < 24; n++) begin
      logic [15:0] a, b, ga, oa, gb, ob;
      a = 16'($urandom); b = 16'($urandom);
      ga = 16'($urandom); oa = 16'($urandom);
      gb = 16'($urandom); ob = 16'($urandom);
      runMeas("R6 R7 R8 random", a, b, ga, oa, gb, ob,
              model(a, ga, oa), model(b, gb, ob), 1 + (n % 4));
    end
  endtask

  initial begin
    void'($urandom(32'h1eaf));
    repeat (2) @(negedge clk);
    testReset();
    testKnownValues();
    testChannels();
    testExtremes();
    testRandom();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule